// File: doc/BRIEF.md
# Single-Slope PWM Generator

This block produces pulse-width-modulated waveforms from one up-counter that climbs from zero to a selectable ceiling and then drops straight back to zero. Two output channels compare the running count against their own duty values. Each channel drives its output either high from the duty match until the ceiling (non-inverting) or low over that same stretch (inverting). One counter ramp per period gives twice the output rate of a counter that climbs and then descends to the same ceiling.

A 4-bit mode input picks where the ceiling comes from. It can be one of three fixed values, a directly written period register, or the active duty value of channel A. Duty writes land in a shadow buffer. The shadow is copied into the working value only when the counter wraps, so a period never sees a half-changed threshold. A tick-enable input lets a shared prescaler slow the count. One-cycle event pulses mark each wrap and each duty match.

Top module: `fpwm_gen`

## Requirements
- R1: Mode 5, 6 and 7 use a ceiling of 255, 511 and 1023. With tick held high, wrap pulses are TOP+1 cycles apart.
- R2: Mode 14 takes the ceiling from the period register at write address 2. That register is written directly with no shadow.
- R3: Mode 15 takes the ceiling from channel A's active duty value.
- R4: With output mode 2'b10 (non-inverting), a channel's output is high for TOP−D of the TOP+1 ticks in each period, where D is its duty value and D is below TOP.
- R5: With output mode 2'b11 (inverting), the output is low for TOP−D ticks and high for D+1 ticks in each period.
- R6: When D equals TOP, the ceiling action wins. A non-inverting output then stays low for the whole period. The same happens when D is above TOP.
- R7: Duty writes (address 0 = channel A, address 1 = channel B) go to a shadow. The active duty value takes the shadow only on a wrap. A write made during a period leaves that period's match point unchanged.
- R8: The overflow flag pulses for one cycle after the tick on which the count is at or above TOP. A channel's compare flag pulses after the tick on which the count equals its active duty value.
- R9: The count advances only on cycles with tick high. With tick low, no flag pulses and the outputs hold.
- R10: If the ceiling is lowered below the current count, the counter wraps on the next tick.
- R11: Any mode other than 5, 6, 7, 14 or 15 holds the count at zero, gives no flags, drives both outputs low, and lets the active duty values follow their shadows.
- R12: Output modes 2'b00 and 2'b01 force the channel output low.
- R13: After reset, all outputs and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from a prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 duty A shadow, 1 duty B shadow, 2 period register, 3 unused |
| wr_data | input | CNT_W | Write data |
| mode | input | 4 | Ceiling source / run select |
| out_mode_a | input | 2 | Channel A output mode |
| out_mode_b | input | 2 | Channel B output mode |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Wrap event pulse |
| cmpa_flag | output | 1 | Channel A match pulse |
| cmpb_flag | output | 1 | Channel B match pulse |

## Verification
A wrong count or ceiling shows up as a changed gap between wrap pulses, within one period of the fault. A wrong active duty value moves the match pulse, which appears a fixed number of ticks after the wrap. It also changes the count of high cycles in the same period. A shadow that loads early shifts the match pulse in the period of the write rather than the next one. Each of these is visible by the next wrap at the latest.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

   typedef enum logic [2:0] {
      TS_IDLE,
      TS_FIX8,
      TS_FIX9,
      TS_FIX10,
      TS_PERIOD,
      TS_DUTYA
   } fpwm_topsrc_e;

   localparam logic [1:0] OM_OFF    = 2'b00;
   localparam logic [1:0] OM_RSVD   = 2'b01;
   localparam logic [1:0] OM_NONINV = 2'b10;
   localparam logic [1:0] OM_INV    = 2'b11;

   localparam logic [1:0] ADDR_PERIOD = 2'd2;

   function automatic fpwm_topsrc_e fpwm_decode(input logic [3:0] m);
      case (m)
         4'd5:    return TS_FIX8;
         4'd6:    return TS_FIX9;
         4'd7:    return TS_FIX10;
         4'd14:   return TS_PERIOD;
         4'd15:   return TS_DUTYA;
         default: return TS_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/fpwm_topsel.sv
module fpwm_topsel
   import fpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [3:0]       mode,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] duty_a,
   output logic [CNT_W-1:0] top,
   output logic             run
);

   localparam logic [CNT_W-1:0] TOP8  = CNT_W'(255);
   localparam logic [CNT_W-1:0] TOP9  = CNT_W'(511);
   localparam logic [CNT_W-1:0] TOP10 = CNT_W'(1023);

   if (CNT_W < 10) begin : g_bad_width
      $error("fpwm_topsel: CNT_W must hold the 10-bit fixed ceiling");
   end

   fpwm_topsrc_e src;

   always_comb begin
      src = fpwm_decode(mode);
      run = (src != TS_IDLE);
      case (src)
         TS_FIX8:   top = TOP8;
         TS_FIX9:   top = TOP9;
         TS_FIX10:  top = TOP10;
         TS_PERIOD: top = period;
         TS_DUTYA:  top = duty_a;
         default:   top = '0;
      endcase
   end

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] count,
   output logic             wrap,
   output logic             ovf
);

   logic [CNT_W-1:0] count_q;
   logic             ovf_q;

   assign wrap  = run && tick && (count_q >= top);
   assign count = count_q;
   assign ovf   = ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         ovf_q <= wrap;
         if (!run)
            count_q <= '0;
         else if (wrap)
            count_q <= '0;
         else if (tick)
            count_q <= count_q + CNT_W'(1);
      end
   end

   // R1 / R10: a tick at or past the ceiling returns the count to zero
   p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && count_q >= top) |=> (count_q == '0));

   // R8: an overflow pulse always coincides with a fresh period
   p_ovf_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> (count_q == '0));

   // R9: no tick, no movement
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(count_q));

   // R11: outside the PWM modes the counter sits at zero with no pulses
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (count_q == '0 && !ovf_q));

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
   import fpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             wrap,
   input  logic [CNT_W-1:0] count,
   input  logic             wr_stb,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       out_mode,
   output logic [CNT_W-1:0] duty_act,
   output logic             pwm,
   output logic             match
);

   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] act_q;
   logic             level_q;
   logic             match_q;
   logic             hit;
   logic             inv;

   assign inv      = (out_mode == OM_INV);
   assign hit      = run && tick && (count == act_q);
   assign duty_act = act_q;
   assign match    = match_q;
   assign pwm      = out_mode[1] && level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         act_q    <= '0;
         level_q  <= 1'b0;
         match_q  <= 1'b0;
      end else begin
         if (wr_stb)
            shadow_q <= wr_data;
         if (!run || wrap)
            act_q <= shadow_q;
         match_q <= hit;
         if (!run)
            level_q <= 1'b0;
         else if (wrap)
            level_q <= inv;
         else if (hit)
            level_q <= !inv;
      end
   end

   // R7: the working duty value picks up the shadow on a wrap
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (act_q == $past(shadow_q)));

   // R7: between wraps the working duty value does not move
   p_act_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> $stable(act_q));

   // R6: ceiling action beats a coincident match for a non-inverting channel
   p_top_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && out_mode == OM_NONINV) |=> !level_q);

   // R12: disabled output modes never drive high
   p_off_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_mode[1] |-> !pwm);

endmodule

// File: rtl/fpwm_gen.sv
module fpwm_gen
   import fpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [3:0]       mode,
   input  logic [1:0]       out_mode_a,
   input  logic [1:0]       out_mode_b,
   output logic             pwm_a,
   output logic             pwm_b,
   output logic             ovf_flag,
   output logic             cmpa_flag,
   output logic             cmpb_flag
);

   localparam int N_CH = 2;

   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] top;
   logic [CNT_W-1:0] count;
   logic             run;
   logic             wrap;
   logic             ovf;

   logic [1:0]       om   [N_CH];
   logic [CNT_W-1:0] duty [N_CH];
   logic             pwm  [N_CH];
   logic             hitq [N_CH];

   assign om[0] = out_mode_a;
   assign om[1] = out_mode_b;

   always_ff @(posedge clk) begin
      if (!rst_n)
         period_q <= '0;
      else if (wr_en && wr_addr == ADDR_PERIOD)
         period_q <= wr_data;
   end

   fpwm_topsel #(.CNT_W(CNT_W)) u_topsel (
      .mode   (mode),
      .period (period_q),
      .duty_a (duty[0]),
      .top    (top),
      .run    (run)
   );

   fpwm_counter #(.CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (run),
      .top   (top),
      .count (count),
      .wrap  (wrap),
      .ovf   (ovf)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      fpwm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run),
         .tick     (tick),
         .wrap     (wrap),
         .count    (count),
         .wr_stb   (wr_en && wr_addr == 2'(i)),
         .wr_data  (wr_data),
         .out_mode (om[i]),
         .duty_act (duty[i]),
         .pwm      (pwm[i]),
         .match    (hitq[i])
      );
   end

   assign pwm_a     = pwm[0];
   assign pwm_b     = pwm[1];
   assign cmpa_flag = hitq[0];
   assign cmpb_flag = hitq[1];
   assign ovf_flag  = ovf;

   // R11: idle modes keep both outputs low
   p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!pwm_a && !pwm_b));

endmodule

// File: tb/fpwm_gen_test.sv
`timescale 1ns/1ps
module fpwm_gen_test;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [3:0]    mode = 4'd0;
   logic [1:0]    out_mode_a = 2'b00;
   logic [1:0]    out_mode_b = 2'b00;
   logic          pwm_a, pwm_b, ovf_flag, cmpa_flag, cmpb_flag;

   int checks = 0;
   int errors = 0;
   int tick_div = 1;
   int tick_cnt = 0;

   fpwm_gen #(.CNT_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .mode(mode), .out_mode_a(out_mode_a), .out_mode_b(out_mode_b),
      .pwm_a(pwm_a), .pwm_b(pwm_b), .ovf_flag(ovf_flag),
      .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
   );

   always #2 clk = ~clk;

   // tick source: every tick_div cycles, never when tick_div is 0
   initial begin
      forever begin
         @(negedge clk);
         if (tick_div == 0) tick = 1'b0;
         else begin
            tick = (tick_cnt % tick_div) == 0;
            tick_cnt++;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic sync_ovf(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (ovf_flag) begin ok = 1'b1; break; end
      end
   endtask

   task automatic period_len(output int n);
      bit ok;
      sync_ovf(ok);
      n = 0;
      if (!ok) begin n = -1; return; end
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         n++;
         if (ovf_flag) return;
      end
      n = -1;
   endtask

   task automatic high_counts(input int len, output int ha, output int hb);
      bit ok;
      sync_ovf(ok);
      ha = 0; hb = 0;
      for (int i = 0; i < len; i++) begin
         if (i != 0) @(negedge clk);
         if (pwm_a) ha++;
         if (pwm_b) hb++;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!pwm_a && !pwm_b, "R13 outputs low after reset", pwm_a + pwm_b, 0);
      chk(!ovf_flag && !cmpa_flag && !cmpb_flag, "R13 flags low after reset",
          ovf_flag + cmpa_flag + cmpb_flag, 0);
   endtask

   task automatic t_fixed;
      int n, ha, hb;
      mode = 4'd0;
      wr(2'd0, 16); wr(2'd1, 64);
      out_mode_a = 2'b10; out_mode_b = 2'b11;
      mode = 4'd5;
      period_len(n);
      chk(n == 256, "R1 mode 5 period", n, 256);
      high_counts(256, ha, hb);
      chk(ha == 239, "R4 non-inverting high count", ha, 239);
      chk(hb == 65, "R5 inverting high count", hb, 65);
      mode = 4'd6; period_len(n); period_len(n);
      chk(n == 512, "R1 mode 6 period", n, 512);
      mode = 4'd7; period_len(n); period_len(n);
      chk(n == 1024, "R1 mode 7 period", n, 1024);
   endtask

   task automatic t_outmode_off;
      int ha, hb;
      mode = 4'd5;
      out_mode_a = 2'b00; out_mode_b = 2'b01;
      high_counts(256, ha, hb);
      chk(ha == 0, "R12 mode 00 forces low", ha, 0);
      chk(hb == 0, "R12 mode 01 forces low", hb, 0);
   endtask

   task automatic t_period_reg;
      int n;
      mode = 4'd0;
      wr(2'd2, 99);
      mode = 4'd14;
      period_len(n); period_len(n);
      chk(n == 100, "R2 period register ceiling", n, 100);
   endtask

   task automatic t_duty_a_top;
      int n, ha, hb;
      mode = 4'd0;
      wr(2'd0, 49); wr(2'd1, 9);
      out_mode_a = 2'b10; out_mode_b = 2'b10;
      mode = 4'd15;
      period_len(n); period_len(n);
      chk(n == 50, "R3 duty A sets ceiling", n, 50);
      high_counts(50, ha, hb);
      chk(ha == 0, "R6 duty equal to ceiling stays low", ha, 0);
      chk(hb == 40, "R4 channel B in mode 15", hb, 40);
   endtask

   task automatic t_above_top;
      int ha, hb;
      mode = 4'd0;
      wr(2'd2, 99); wr(2'd0, 200); wr(2'd1, 99);
      out_mode_a = 2'b10; out_mode_b = 2'b11;
      mode = 4'd14;
      high_counts(100, ha, hb);
      high_counts(100, ha, hb);
      chk(ha == 0, "R6 duty above ceiling stays low", ha, 0);
      chk(hb == 100, "R6 inverting with duty equal ceiling stays high", hb, 100);
   endtask

   task automatic t_shadow;
      bit ok;
      int n;
      mode = 4'd0;
      wr(2'd2, 99); wr(2'd0, 30); wr(2'd1, 20);
      mode = 4'd14;
      sync_ovf(ok);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = W'(80);
      n = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
         n++;
         if (cmpb_flag) break;
      end
      chk(n == 21, "R7 write mid-period keeps old match", n, 21);
      sync_ovf(ok);
      n = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         n++;
         if (cmpb_flag) break;
      end
      chk(n == 81, "R7 new duty after wrap", n, 81);
      sync_ovf(ok);
      n = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         n++;
         if (cmpa_flag) break;
      end
      chk(n == 31, "R8 compare flag timing", n, 31);
   endtask

   task automatic t_lower_top;
      bit ok;
      int n;
      mode = 4'd14;
      sync_ovf(ok);
      for (int i = 0; i < 50; i++) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = W'(10);
      n = 50;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         wr_en = 1'b0;
         n++;
         if (ovf_flag) break;
      end
      chk(n == 52, "R10 wrap right after ceiling lowered", n, 52);
      period_len(n);
      chk(n == 11, "R10 new period after lowering", n, 11);
   endtask

   task automatic t_tick;
      int n, pulses;
      bit pa;
      mode = 4'd0;
      wr(2'd2, 9);
      mode = 4'd14;
      tick_div = 2;
      period_len(n); period_len(n);
      chk(n == 20, "R9 half-rate tick doubles period", n, 20);
      tick_div = 0;
      @(negedge clk); @(negedge clk);
      pa = pwm_b;
      pulses = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (ovf_flag || cmpa_flag || cmpb_flag || pwm_b != pa) pulses++;
      end
      chk(pulses == 0, "R9 frozen without tick", pulses, 0);
      tick_div = 1;
   endtask

   task automatic t_idle;
      int bad;
      out_mode_a = 2'b11; out_mode_b = 2'b10;
      mode = 4'd3;
      bad = 0;
      @(negedge clk);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (ovf_flag || cmpa_flag || cmpb_flag || pwm_a || pwm_b) bad++;
      end
      chk(bad == 0, "R11 idle mode silent", bad, 0);
   endtask

   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fixed();
      t_outmode_off();
      t_period_reg();
      t_duty_a_top();
      t_above_top();
      t_shadow();
      t_lower_top();
      t_tick();
      t_idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule